// File: doc/BRIEF.md
# Key-Parameterized Symmetric Wavelet Analysis Filter

This block is the arithmetic core of a key-driven wavelet transform stage. Each clock it may take one signed sample into a nine-entry sliding window. Each pair of taps at equal distance from the centre is added before any multiply, which leaves five operands. Two filter results come out for every window position. The nine-tap result uses all five folded operands. The seven-tap result uses the four nearest ones. Both are fixed-point sums of products with runtime-loaded constants, then rounded and clamped to the output width.

The constants belong to one value of a free parameter `a`. That parameter lies in the range 1 to 3, split into `2^m` equal steps, and an m-bit key field picks the step. Turning the key into constants is done outside the block. Software writes the constants one at a time into a staging bank, then issues a single commit strobe. The whole set then becomes active at once, so no output mixes constants from two keys. For the seven-tap filter, the constants at distances 0 through 3 are (1/4 + a/8), (7/32 + a/32), (1/8 − a/16) and (1/32 − a/32).

Downsampling, row and column sequencing, and multi-level control belong to the surrounding datapath.

Top module: `keyed_wavelet_filter`

## Requirements
- R1: While `rst_ni` is low and afterwards until the window fills, `out_valid_o` is 0, `lp_o` and `hp_o` are 0, and every active and staged constant is 0.
- R2: A sample is taken only on a rising edge with `in_valid_i` high, and data presented with `in_valid_i` low is ignored. The first valid output needs nine accepted samples since reset. It appears on the fifth rising edge after the edge that accepts the ninth sample. Every later accepted sample gives exactly one valid output with the same latency, and no other cycle has `out_valid_o` high.
- R3: For a window whose oldest to newest samples are x0..x8, the folded operands are w0 = x4 and wi = x(4−i) + x(4+i) for i = 1..4.
- R4: `lp_o` is the rounded sum of L[i]·wi over i = 0..4. `hp_o` is the rounded sum of H[i]·wi over i = 0..3, so x0 and x8 never affect `hp_o`.
- R5: Constant address map on `cfg_addr_i`: addresses 0..4 hold L[0..4], addresses 5..8 hold H[0..3], and writes to addresses 9..15 change nothing.
- R6: A write with `cfg_we_i` only updates the staging bank. On a rising edge with `cfg_commit_i` high, the whole staging bank is copied to the active set, including a write made on that same edge. Without a commit, outputs keep using the previous active set.
- R7: Constants are two's-complement words of COEF_W bits with FRAC_W fractional bits. A sum S gives floor((S + 2^(FRAC_W−1)) / 2^FRAC_W), which rounds half toward plus infinity.
- R8: A rounded value above 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1. A rounded value below −2^(OUT_W−1) is output as −2^(OUT_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | DATA_W | Signed input sample |
| cfg_we_i | input | 1 | Staging write enable |
| cfg_addr_i | input | 4 | Constant index |
| cfg_data_i | input | COEF_W | Signed fixed-point constant |
| cfg_commit_i | input | 1 | Copy the staging bank to the active set |
| out_valid_o | output | 1 | Output results are valid |
| lp_o | output | OUT_W | Nine-tap filter result |
| hp_o | output | OUT_W | Seven-tap filter result |

## Verification
Three situations are hard to set up from the ports. The first is a constant change that must not reach the outputs: staged writes with no commit, and writes to the unused addresses. The bench sets this up by streaming fresh samples after such writes and comparing against the previous constant set. The second is a write and a commit on the same edge, which is placed right before a new stream. The third is clamping: the bench loads extreme constants and feeds full-scale samples of both signs. A key sweep loads constants computed from `a` for every step of a 3-bit key, and a full ramp across the input range with gaps in the sample strobe checks the window alignment.

// File: rtl/kwf_pkg.sv
package kwf_pkg;
  localparam int HALF   = 4;
  localparam int TAPS   = 2 * HALF + 1;
  localparam int N_LP   = HALF + 1;
  localparam int N_HP   = HALF;
  localparam int N_COEF = N_LP + N_HP;
  localparam int ADDR_W = 4;
endpackage

// File: rtl/kwf_tap_window.sv
module kwf_tap_window
  import kwf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     fold_valid_o,
  output logic signed [DATA_W:0]   fold_o [N_LP]
);
  localparam int FILL_W = $clog2(TAPS + 1);

  logic signed [DATA_W-1:0] tap_q [TAPS];
  logic [FILL_W-1:0]        fill_q;
  logic                     win_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q      <= '0;
      win_valid_q <= 1'b0;
    end else begin
      win_valid_q <= in_valid_i && (fill_q == FILL_W'(TAPS - 1));
      if (in_valid_i && fill_q != FILL_W'(TAPS - 1)) fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[t] <= '0;
      else if (in_valid_i) tap_q[t] <= (t == 0) ? in_data_i : tap_q[(t == 0) ? 0 : t-1];
    end
  end

  // tap_q[0] newest; centre at HALF
  for (genvar i = 0; i < N_LP; i++) begin : g_fold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fold_o[i] <= '0;
      else if (i == 0) fold_o[i] <= (DATA_W+1)'(tap_q[HALF]);
      else fold_o[i] <= (DATA_W+1)'(tap_q[HALF-i]) + (DATA_W+1)'(tap_q[HALF+i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fold_valid_o <= 1'b0;
    else fold_valid_o <= win_valid_q;
  end

  assert_no_early_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q < FILL_W'(TAPS - 1)) |=> !win_valid_q);
endmodule

// File: rtl/kwf_coef_bank.sv
module kwf_coef_bank
  import kwf_pkg::*;
#(
  parameter int COEF_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic signed [COEF_W-1:0] data_i,
  input  logic                     commit_i,
  output logic signed [COEF_W-1:0] lp_o [N_LP],
  output logic signed [COEF_W-1:0] hp_o [N_HP]
);
  logic signed [COEF_W-1:0] stage_q [N_COEF];
  logic signed [COEF_W-1:0] stage_d [N_COEF];
  logic signed [COEF_W-1:0] act_q   [N_COEF];

  for (genvar j = 0; j < N_COEF; j++) begin : g_entry
    always_comb stage_d[j] = (we_i && addr_i == ADDR_W'(j)) ? data_i : stage_q[j];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[j] <= '0;
        act_q[j]   <= '0;
      end else begin
        stage_q[j] <= stage_d[j];
        if (commit_i) act_q[j] <= stage_d[j];
      end
    end

    assert_hold_uncommitted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(act_q[j]));
  end

  for (genvar i = 0; i < N_LP; i++) begin : g_lp
    assign lp_o[i] = act_q[i];
  end
  for (genvar i = 0; i < N_HP; i++) begin : g_hp
    assign hp_o[i] = act_q[N_LP + i];
  end
endmodule

// File: rtl/kwf_mac.sv
module kwf_mac #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int NCO    = 5,
  parameter int SUM_W  = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W:0]   w_i [NCO],
  input  logic signed [COEF_W-1:0] c_i [NCO],
  output logic                     valid_o,
  output logic signed [SUM_W-1:0]  sum_o
);
  localparam int PROD_W = DATA_W + 1 + COEF_W;
  localparam int NP     = (NCO + 1) / 2;

  logic signed [PROD_W-1:0] prod_q [NCO];
  logic signed [PROD_W:0]   part_q [NP];
  logic signed [SUM_W-1:0]  sum_d;
  logic [2:0]               v_q;

  for (genvar i = 0; i < NCO; i++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[i] <= '0;
      else prod_q[i] <= PROD_W'(w_i[i]) * PROD_W'(c_i[i]);
    end
  end

  for (genvar j = 0; j < NP; j++) begin : g_part
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) part_q[j] <= '0;
      else if (2*j+1 < NCO)
        part_q[j] <= (PROD_W+1)'(prod_q[2*j]) + (PROD_W+1)'(prod_q[(2*j+1 < NCO) ? 2*j+1 : 2*j]);
      else
        part_q[j] <= (PROD_W+1)'(prod_q[2*j]);
    end
  end

  always_comb begin
    sum_d = '0;
    for (int j = 0; j < NP; j++) sum_d = sum_d + SUM_W'(part_q[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      v_q   <= '0;
    end else begin
      sum_o <= sum_d;
      v_q   <= {v_q[1:0], valid_i};
    end
  end
  assign valid_o = v_q[2];

  assert_mac_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o);
endmodule

// File: rtl/kwf_round_sat.sv
module kwf_round_sat #(
  parameter int SUM_W  = 22,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam logic signed [SUM_W:0] MAXV = (SUM_W+1)'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SUM_W:0] MINV = -(SUM_W+1)'(1 << (OUT_W-1));

  logic signed [SUM_W:0] biased, shifted;

  always_comb begin
    biased  = {sum_i[SUM_W-1], sum_i} + (SUM_W+1)'(1 << (FRAC_W-1));
    shifted = biased >>> FRAC_W;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else if (en_i) begin
      if (shifted > MAXV)      res_o <= OUT_W'(MAXV);
      else if (shifted < MINV) res_o <= OUT_W'(MINV);
      else                     res_o <= OUT_W'(shifted);
    end
  end

  assert_clamp_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && shifted > MAXV) |=> (res_o == OUT_W'(MAXV)));
  assert_clamp_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && shifted < MINV) |=> (res_o == OUT_W'(MINV)));
endmodule

// File: rtl/keyed_wavelet_filter.sv
module keyed_wavelet_filter
  import kwf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic                     cfg_we_i,
  input  logic [ADDR_W-1:0]        cfg_addr_i,
  input  logic signed [COEF_W-1:0] cfg_data_i,
  input  logic                     cfg_commit_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  lp_o,
  output logic signed [OUT_W-1:0]  hp_o
);
  localparam int SUM_W = DATA_W + 1 + COEF_W + 3;

  logic                     fold_valid;
  logic signed [DATA_W:0]   fold [N_LP];
  logic signed [DATA_W:0]   hp_w [N_HP];
  logic signed [COEF_W-1:0] lp_c [N_LP];
  logic signed [COEF_W-1:0] hp_c [N_HP];
  logic                     lp_v, hp_v;
  logic signed [SUM_W-1:0]  lp_sum, hp_sum;

  kwf_tap_window #(.DATA_W(DATA_W)) u_window (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i,
    .fold_valid_o(fold_valid), .fold_o(fold)
  );

  kwf_coef_bank #(.COEF_W(COEF_W)) u_coef (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .commit_i(cfg_commit_i), .lp_o(lp_c), .hp_o(hp_c)
  );

  for (genvar i = 0; i < N_HP; i++) begin : g_hpw
    assign hp_w[i] = fold[i];
  end

  kwf_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NCO(N_LP), .SUM_W(SUM_W)) u_mac_lp (
    .clk_i, .rst_ni, .valid_i(fold_valid), .w_i(fold), .c_i(lp_c),
    .valid_o(lp_v), .sum_o(lp_sum)
  );

  kwf_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NCO(N_HP), .SUM_W(SUM_W)) u_mac_hp (
    .clk_i, .rst_ni, .valid_i(fold_valid), .w_i(hp_w), .c_i(hp_c),
    .valid_o(hp_v), .sum_o(hp_sum)
  );

  kwf_round_sat #(.SUM_W(SUM_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rs_lp (
    .clk_i, .rst_ni, .en_i(lp_v), .sum_i(lp_sum), .res_o(lp_o)
  );

  kwf_round_sat #(.SUM_W(SUM_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rs_hp (
    .clk_i, .rst_ni, .en_i(hp_v), .sum_i(hp_sum), .res_o(hp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else out_valid_o <= lp_v & hp_v;
  end

  assert_paths_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_v == hp_v);
  assert_out_follows_fold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_valid |-> ##4 out_valid_o);
endmodule

// File: tb/keyed_wavelet_filter_bench.sv
module keyed_wavelet_filter_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic signed [7:0] in_data_i = '0;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_addr_i = '0;
  logic signed [9:0] cfg_data_i = '0;
  logic cfg_commit_i = 1'b0;
  logic out_valid_o;
  logic signed [11:0] lp_o, hp_o;

  keyed_wavelet_filter u_keyed_wavelet_filter (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int xs [8192];
  int acc_cyc [8192];
  int nacc = 0, nout = 0, ncyc = 0;
  int mdl_lp [5];
  int mdl_hp [4];
  bit done = 0;

  function automatic int rsat(longint s);
    longint t;
    t = (s + 128) >>> 8;
    if (t > 2047) t = 2047;
    if (t < -2048) t = -2048;
    return int'(t);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    ncyc++;
    if (!rst_ni) begin
      nacc = 0; nout = 0;
      chk("R1 valid in reset", int'(out_valid_o), 0);
      chk("R1 lp in reset", int'(lp_o), 0);
      chk("R1 hp in reset", int'(hp_o), 0);
    end else begin
      if (out_valid_o) begin
        int j; longint sl, sh; int w [5];
        j = nout;
        if (j + 8 >= nacc) chk("R2 output without full window", 1, 0);
        else begin
          w[0] = xs[j+4];
          for (int i = 1; i < 5; i++) w[i] = xs[j+4-i] + xs[j+4+i];
          sl = 0; sh = 0;
          for (int i = 0; i < 5; i++) sl += longint'(mdl_lp[i]) * w[i];
          for (int i = 0; i < 4; i++) sh += longint'(mdl_hp[i]) * w[i];
          chk("R2 latency", ncyc, acc_cyc[j+8] + 6);
          chk("R3/R4/R7/R8 lp", int'(lp_o), rsat(sl));
          chk("R3/R4/R7/R8 hp", int'(hp_o), rsat(sh));
        end
        nout++;
      end
      if (in_valid_i) begin
        xs[nacc] = int'(in_data_i);
        acc_cyc[nacc] = ncyc;
        nacc++;
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wcoef(int addr, int val);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(addr); cfg_data_i = 10'(val);
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic commit();
    cfg_commit_i = 1'b1;
    step();
    cfg_commit_i = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_data_i = 8'($urandom);
      step();
    end
  endtask

  task automatic send(int v);
    in_valid_i = 1'b1; in_data_i = 8'(v);
    step();
    in_valid_i = 1'b0;
  endtask

  task automatic stream_rand(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      send(int'($urandom_range(255)) - 128);
      if (gaps && ($urandom_range(3) == 0)) idle(int'($urandom_range(2)) + 1);
    end
    idle(10);
  endtask

  task automatic count_check(string req);
    chk(req, nout, (nacc >= 9) ? nacc - 8 : 0);
  endtask

  task automatic load_set(int l [5], int h [4]);
    for (int i = 0; i < 5; i++) wcoef(i, l[i]);
    for (int i = 0; i < 4; i++) wcoef(5 + i, h[i]);
    commit();
    mdl_lp = l; mdl_hp = h;
  endtask

  function automatic int fx(real v);
    return $rtoi($floor(v * 256.0 + 0.5));
  endfunction

  task automatic do_reset();
    in_valid_i = 1'b0;
    #3 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) mdl_lp[i] = 0;
    for (int i = 0; i < 4; i++) mdl_hp[i] = 0;
    step();
  endtask

  initial begin : main
    int l [5]; int h [4];
    do_reset();
    // R1: constants zero after reset, outputs zero
    stream_rand(14, 0);
    count_check("R2 output count after reset");

    // R4/R7: key sweep, 3-bit key
    for (int k = 0; k < 8; k++) begin
      real a;
      a = 1.0 + 2.0 * k / 8.0;
      l[4] = fx(-9.0*a/64.0 + a*a/32.0 + 15.0/64.0 - 1.0/(8.0*a));
      l[3] = fx(-a*a/16.0 + 11.0*a/32.0 - 11.0/16.0 + 1.0/(2.0*a));
      l[2] = fx(1.0/8.0 - 1.0/(2.0*a));
      l[1] = fx(-11.0*a/32.0 + a*a/16.0 + 15.0/16.0 - 1.0/(2.0*a));
      l[0] = fx(9.0*a/32.0 - a*a/16.0 - 7.0/32.0 + 5.0/(4.0*a));
      h[0] = fx(0.25 + a/8.0);
      h[1] = fx(7.0/32.0 + a/32.0);
      h[2] = fx(1.0/8.0 - a/16.0);
      h[3] = fx(1.0/32.0 - a/32.0);
      load_set(l, h);
      stream_rand(20, 1);
    end
    count_check("R2 output count key sweep");

    // R3: full-range ramp with gaps
    for (int v = -128; v < 128; v++) begin
      send(v);
      if (v % 7 == 0) idle(1);
    end
    idle(10);
    count_check("R2 output count ramp");

    // R5: unused addresses ignored, R6: staged without commit ignored
    for (int a2 = 9; a2 < 16; a2++) wcoef(a2, 511);
    for (int i = 0; i < 9; i++) wcoef(i, -300 + 37 * i);
    stream_rand(16, 0);
    // commit now: R6 staged values take effect, R5 unused writes still absent
    commit();
    for (int i = 0; i < 5; i++) mdl_lp[i] = -300 + 37 * i;
    for (int i = 0; i < 4; i++) mdl_hp[i] = -300 + 37 * (5 + i);
    stream_rand(16, 1);

    // R6: write and commit on the same edge
    cfg_we_i = 1'b1; cfg_addr_i = 4'd8; cfg_data_i = 10'sd200; cfg_commit_i = 1'b1;
    step();
    cfg_we_i = 1'b0; cfg_commit_i = 1'b0;
    mdl_hp[3] = 200;
    stream_rand(14, 0);

    // R8: saturation both ways
    for (int i = 0; i < 5; i++) l[i] = 511;
    for (int i = 0; i < 4; i++) h[i] = 511;
    load_set(l, h);
    for (int k = 0; k < 12; k++) send(127);
    for (int k = 0; k < 12; k++) send(-128);
    idle(10);
    for (int i = 0; i < 5; i++) l[i] = -512;
    for (int i = 0; i < 4; i++) h[i] = -512;
    load_set(l, h);
    for (int k = 0; k < 12; k++) send(-128);
    for (int k = 0; k < 12; k++) send(127);
    idle(10);
    stream_rand(20, 1);
    count_check("R2 output count saturation");

    // R2/R1: reset mid-stream restarts the fill and clears constants
    for (int k = 0; k < 5; k++) send(k * 9);
    do_reset();
    stream_rand(8, 0);
    chk("R2 no output before nine samples", nout, 0);
    stream_rand(6, 0);
    count_check("R2 output count after re-reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule